// File: doc/BRIEF.md
# Graphics Request to Link Request Translator

This block sits between a graphics port's request queue and a packet link. Each request comes with a priority flag and a kind (write, read, flush or fence). The block turns it into a link request descriptor that holds a command, a channel selector and two ordering bits: one for the request and one for its response. Descriptors go out through a single registered stage, in the order the requests arrived.

The block also counts reads that are still waiting for data. A fence produces no link packet. Once a fence is taken while reads are outstanding, every later request is held until the count returns to zero.

Read responses return through a one-entry completion register. A response marked with the "no target" status still completes without error, and its data is forced to all ones. A response is counted as retired, and the outstanding count drops, when the consumer acknowledges the completion.

Top module: `gfx_req_xlat`

## Requirements
- R1: A high-priority write (req_kind 0, req_hipri 1) leaves with lnk_cmd 0 (sized write), lnk_posted 1, lnk_pass 1 and lnk_rsp_pass 0.
- R2: A high-priority read (req_kind 1, req_hipri 1) leaves with lnk_cmd 1 (sized read), lnk_posted 0, lnk_pass 1 and lnk_rsp_pass 1.
- R3: A low-priority write leaves with lnk_cmd 0, lnk_posted 1, lnk_pass 0 and lnk_rsp_pass 0.
- R4: A low-priority read leaves with lnk_cmd 1, lnk_posted 0, lnk_pass 0 and lnk_rsp_pass 1.
- R5: A flush (req_kind 2) leaves with lnk_cmd 2, lnk_posted 0, lnk_pass 0 and lnk_rsp_pass 0, whatever its priority.
- R6: A fence (req_kind 3) produces no link packet. If reads remain outstanding after the fence is accepted, req_ready stays low until the last of them has been acknowledged on the completion side.
- R7: A fence accepted while no read is outstanding is retired in the same cycle, and the next request can be accepted in the following cycle.
- R8: A response with rsp_status 1 ("no target") completes with cmp_err 0 and cmp_data all ones, whatever rsp_data holds.
- R9: A response with rsp_status 0 completes with cmp_data equal to rsp_data and cmp_err 0. Status 2 or 3 completes with cmp_data equal to rsp_data and cmp_err 1. rsp_ready is high whenever the completion register is empty or is being acknowledged.
- R10: With MAX_OUT reads outstanding, a read at the head of the input is held with req_ready low.
- R11: Every non-fence request produces exactly one link packet, in acceptance order, carrying req_addr and req_data unchanged. lnk_valid rises in the cycle after acceptance.
- R12: While lnk_valid is high and lnk_ready is low, the link descriptor stays valid and unchanged.
- R13: After reset, lnk_valid and cmp_valid are 0 and req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_hipri | input | 1 | High-priority flag |
| req_kind | input | 2 | 0 write, 1 read, 2 flush, 3 fence |
| req_addr | input | AW | Request address |
| req_data | input | DW | Write data |
| lnk_valid | output | 1 | Link descriptor valid |
| lnk_ready | input | 1 | Link accepts descriptor |
| lnk_cmd | output | 2 | 0 sized write, 1 sized read, 2 flush |
| lnk_posted | output | 1 | Posted channel select |
| lnk_pass | output | 1 | Request ordering-pass bit |
| lnk_rsp_pass | output | 1 | Response ordering-pass bit |
| lnk_addr | output | AW | Descriptor address |
| lnk_data | output | DW | Descriptor data |
| rsp_valid | input | 1 | Read response present |
| rsp_ready | output | 1 | Response taken this cycle when valid |
| rsp_status | input | 2 | 0 ok, 1 no target, 2/3 error |
| rsp_data | input | DW | Response data |
| cmp_valid | output | 1 | Completion valid |
| cmp_ack | input | 1 | Completion consumed |
| cmp_data | output | DW | Completion data |
| cmp_err | output | 1 | Completion error flag |

## Verification
The hardest states to reach are a saturated read counter and a fence waiting behind outstanding reads. Random traffic almost never gets there, because the responder keeps draining reads. The stimulus therefore switches the responder off, sends a burst of MAX_OUT+1 reads through a link that is always ready, and confirms that the last read is stalled. A second directed pass places two reads, a fence and a write in sequence with responses withheld. It confirms that the write is held, then lets the responses flow and checks that the write follows. Random phases vary the link-ready and acknowledge rates so that back-pressure, simultaneous increment and decrement of the counter, and the "no target" data override all occur often.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    K_WRITE = 2'd0,
    K_READ  = 2'd1,
    K_FLUSH = 2'd2,
    K_FENCE = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    C_WRSZ  = 2'd0,
    C_RDSZ  = 2'd1,
    C_FLUSH = 2'd2,
    C_NONE  = 2'd3
  } lnk_cmd_e;

  typedef enum logic [1:0] {
    S_OK   = 2'd0,
    S_NOTG = 2'd1,
    S_ERRA = 2'd2,
    S_ERRB = 2'd3
  } rsp_stat_e;

  typedef struct packed {
    lnk_cmd_e cmd;
    logic     posted;
    logic     pass;
    logic     rsp_pass;
  } lnk_attr_t;

endpackage

// File: rtl/xlat_decode.sv
module xlat_decode
  import xlat_pkg::*;
(
  input  logic       hipri,
  input  logic [1:0] kind,
  output lnk_attr_t  attr,
  output logic       is_read,
  output logic       is_fence
);

  req_kind_e k;
  assign k = req_kind_e'(kind);

  always_comb begin
    attr     = '{cmd: C_NONE, posted: 1'b0, pass: 1'b0, rsp_pass: 1'b0};
    is_read  = 1'b0;
    is_fence = 1'b0;
    case (k)
      K_WRITE: begin
        attr.cmd    = C_WRSZ;
        attr.posted = 1'b1;
        attr.pass   = hipri;
      end
      K_READ: begin
        attr.cmd      = C_RDSZ;
        attr.pass     = hipri;
        attr.rsp_pass = 1'b1;
        is_read       = 1'b1;
      end
      K_FLUSH: begin
        attr.cmd = C_FLUSH;
      end
      default: begin
        is_fence = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/xlat_rd_tracker.sv
module xlat_rd_tracker #(
  parameter int MAX_OUT = 16,
  parameter int CW      = $clog2(MAX_OUT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          dec,
  output logic          full,
  output logic          zero_next,
  output logic [CW-1:0] cnt
);

  localparam logic [CW-1:0] LIMIT = CW'(MAX_OUT);
  localparam logic [CW-1:0] ONE   = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (inc && !dec)      cnt_d = cnt_q + ONE;
    else if (!inc && dec) cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign full      = (cnt_q == LIMIT);
  assign zero_next = (cnt_d == '0);
  assign cnt       = cnt_q;

endmodule

// File: rtl/xlat_out_stage.sv
module xlat_out_stage
  import xlat_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  lnk_attr_t     attr_in,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  input  logic          ready,
  output logic          free,
  output logic          valid,
  output lnk_attr_t     attr_out,
  output logic [AW-1:0] addr_out,
  output logic [DW-1:0] data_out
);

  logic          valid_q;
  lnk_attr_t     attr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  assign free = !valid_q || ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      attr_q  <= '{cmd: C_NONE, posted: 1'b0, pass: 1'b0, rsp_pass: 1'b0};
      addr_q  <= '0;
      data_q  <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      attr_q  <= attr_in;
      addr_q  <= addr_in;
      data_q  <= data_in;
    end else if (ready) begin
      valid_q <= 1'b0;
    end
  end

  assign valid    = valid_q;
  assign attr_out = attr_q;
  assign addr_out = addr_q;
  assign data_out = data_q;

endmodule

// File: rtl/xlat_cmp_path.sv
module xlat_cmp_path
  import xlat_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rsp_valid,
  input  logic [1:0]    rsp_status,
  input  logic [DW-1:0] rsp_data,
  output logic          rsp_ready,
  input  logic          cmp_ack,
  output logic          cmp_valid,
  output logic [DW-1:0] cmp_data,
  output logic          cmp_err,
  output logic          consumed
);

  logic          vld_q;
  logic [DW-1:0] data_q, data_d;
  logic          err_q, err_d;
  logic          take;

  assign rsp_ready = !vld_q || cmp_ack;
  assign take      = rsp_valid && rsp_ready;
  assign consumed  = vld_q && cmp_ack;

  always_comb begin
    data_d = rsp_data;
    err_d  = 1'b0;
    case (rsp_stat_e'(rsp_status))
      S_OK:    err_d  = 1'b0;
      S_NOTG:  data_d = '1;
      default: err_d  = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      data_q <= '0;
      err_q  <= 1'b0;
    end else if (take) begin
      vld_q  <= 1'b1;
      data_q <= data_d;
      err_q  <= err_d;
    end else if (cmp_ack) begin
      vld_q  <= 1'b0;
    end
  end

  assign cmp_valid = vld_q;
  assign cmp_data  = data_q;
  assign cmp_err   = err_q;

endmodule

// File: rtl/gfx_req_xlat.sv
module gfx_req_xlat
  import xlat_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int MAX_OUT = 16,
  localparam int CW     = $clog2(MAX_OUT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_hipri,
  input  logic [1:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          lnk_valid,
  input  logic          lnk_ready,
  output logic [1:0]    lnk_cmd,
  output logic          lnk_posted,
  output logic          lnk_pass,
  output logic          lnk_rsp_pass,
  output logic [AW-1:0] lnk_addr,
  output logic [DW-1:0] lnk_data,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic [1:0]    rsp_status,
  input  logic [DW-1:0] rsp_data,
  output logic          cmp_valid,
  input  logic          cmp_ack,
  output logic [DW-1:0] cmp_data,
  output logic          cmp_err
);

  lnk_attr_t     dec_attr, out_attr;
  logic          dec_read, dec_fence;
  logic          lnk_free, rd_full, rd_zero_next;
  logic [CW-1:0] rd_cnt;
  logic          rsp_consumed;
  logic          req_fire;
  logic          fence_q;

  xlat_decode u_dec (
    .hipri    (req_hipri),
    .kind     (req_kind),
    .attr     (dec_attr),
    .is_read  (dec_read),
    .is_fence (dec_fence)
  );

  assign req_ready = !fence_q && lnk_free && !(dec_read && rd_full);
  assign req_fire  = req_valid && req_ready;

  xlat_out_stage #(.AW(AW), .DW(DW)) u_out (
    .clk      (clk),
    .rst      (rst),
    .load     (req_fire && !dec_fence),
    .attr_in  (dec_attr),
    .addr_in  (req_addr),
    .data_in  (req_data),
    .ready    (lnk_ready),
    .free     (lnk_free),
    .valid    (lnk_valid),
    .attr_out (out_attr),
    .addr_out (lnk_addr),
    .data_out (lnk_data)
  );

  assign lnk_cmd      = out_attr.cmd;
  assign lnk_posted   = out_attr.posted;
  assign lnk_pass     = out_attr.pass;
  assign lnk_rsp_pass = out_attr.rsp_pass;

  xlat_rd_tracker #(.MAX_OUT(MAX_OUT), .CW(CW)) u_trk (
    .clk       (clk),
    .rst       (rst),
    .inc       (req_fire && dec_read),
    .dec       (rsp_consumed),
    .full      (rd_full),
    .zero_next (rd_zero_next),
    .cnt       (rd_cnt)
  );

  // Fence hold: set when a fence is taken with reads still pending after
  // this cycle, cleared once the count is about to reach zero.
  always_ff @(posedge clk) begin
    if (rst) fence_q <= 1'b0;
    else     fence_q <= (fence_q || (req_fire && dec_fence)) && !rd_zero_next;
  end

  xlat_cmp_path #(.DW(DW)) u_cmp (
    .clk        (clk),
    .rst        (rst),
    .rsp_valid  (rsp_valid),
    .rsp_status (rsp_status),
    .rsp_data   (rsp_data),
    .rsp_ready  (rsp_ready),
    .cmp_ack    (cmp_ack),
    .cmp_valid  (cmp_valid),
    .cmp_data   (cmp_data),
    .cmp_err    (cmp_err),
    .consumed   (rsp_consumed)
  );

endmodule

// File: rtl/xlat_chk.sv
module xlat_chk #(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int MAX_OUT = 16,
  parameter int CW      = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic [1:0]    req_kind,
  input logic          lnk_valid,
  input logic          lnk_ready,
  input logic [1:0]    lnk_cmd,
  input logic          lnk_posted,
  input logic          lnk_pass,
  input logic          lnk_rsp_pass,
  input logic [AW-1:0] lnk_addr,
  input logic [DW-1:0] lnk_data,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [1:0]    rsp_status,
  input logic          cmp_valid,
  input logic          cmp_ack,
  input logic [DW-1:0] cmp_data,
  input logic          cmp_err,
  input logic          fence_q,
  input logic [CW-1:0] rd_cnt
);

  assert_write_posted_R1: assert property (@(posedge clk) disable iff (rst)
    (lnk_valid && lnk_cmd == 2'd0) |-> (lnk_posted && !lnk_rsp_pass));

  assert_read_nonposted_R2: assert property (@(posedge clk) disable iff (rst)
    (lnk_valid && lnk_cmd == 2'd1) |-> (!lnk_posted && lnk_rsp_pass));

  assert_flush_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (lnk_valid && lnk_cmd == 2'd2) |-> (!lnk_posted && !lnk_pass && !lnk_rsp_pass));

  assert_fence_blocks_R6: assert property (@(posedge clk) disable iff (rst)
    fence_q |-> !req_ready);

  assert_fence_quick_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_kind == 2'd3 && rd_cnt == '0) |=> !fence_q);

  assert_notarget_ones_R8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_ready && rsp_status == 2'd1) |=> (cmp_valid && !cmp_err && cmp_data == '1));

  assert_cmp_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && !cmp_ack) |=> (cmp_valid && $stable(cmp_data) && $stable(cmp_err)));

  assert_read_stall_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 2'd1 && rd_cnt == CW'(MAX_OUT)) |-> !req_ready);

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    rd_cnt <= CW'(MAX_OUT));

  assert_emit_next_R11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_kind != 2'd3) |=> lnk_valid);

  assert_link_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (lnk_valid && !lnk_ready) |=> (lnk_valid && $stable(lnk_cmd) && $stable(lnk_posted)
      && $stable(lnk_pass) && $stable(lnk_rsp_pass) && $stable(lnk_addr) && $stable(lnk_data)));

  assert_reset_idle_R13: assert property (@(posedge clk)
    rst |=> (!lnk_valid && !cmp_valid));

endmodule

bind gfx_req_xlat xlat_chk #(.AW(AW), .DW(DW), .MAX_OUT(MAX_OUT), .CW(CW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_kind     (req_kind),
  .lnk_valid    (lnk_valid),
  .lnk_ready    (lnk_ready),
  .lnk_cmd      (lnk_cmd),
  .lnk_posted   (lnk_posted),
  .lnk_pass     (lnk_pass),
  .lnk_rsp_pass (lnk_rsp_pass),
  .lnk_addr     (lnk_addr),
  .lnk_data     (lnk_data),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_status   (rsp_status),
  .cmp_valid    (cmp_valid),
  .cmp_ack      (cmp_ack),
  .cmp_data     (cmp_data),
  .cmp_err      (cmp_err),
  .fence_q      (fence_q),
  .rd_cnt       (rd_cnt)
);

// File: tb/sim_gfx_req_xlat.sv
module sim_gfx_req_xlat;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 16;
  localparam int DW         = 16;
  localparam int MAXO       = 16;
  localparam int WD_LIMIT   = 150000;

  typedef struct packed {
    logic [1:0]    cmd;
    logic          posted;
    logic          pass;
    logic          rpass;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } pkt_t;

  typedef struct packed {
    logic          hi;
    logic [1:0]    kind;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } req_t;

  typedef struct packed {
    logic [1:0]    st;
    logic          err;
    logic [DW-1:0] data;
  } cmp_t;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid, req_ready, req_hipri;
  logic [1:0]    req_kind;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic          lnk_valid, lnk_ready, lnk_posted, lnk_pass, lnk_rsp_pass;
  logic [1:0]    lnk_cmd;
  logic [AW-1:0] lnk_addr;
  logic [DW-1:0] lnk_data;
  logic          rsp_valid, rsp_ready;
  logic [1:0]    rsp_status;
  logic [DW-1:0] rsp_data;
  logic          cmp_valid, cmp_ack, cmp_err;
  logic [DW-1:0] cmp_data;

  gfx_req_xlat #(.AW(AW), .DW(DW), .MAX_OUT(MAXO)) u0 (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_hipri(req_hipri),
    .req_kind(req_kind), .req_addr(req_addr), .req_data(req_data),
    .lnk_valid(lnk_valid), .lnk_ready(lnk_ready), .lnk_cmd(lnk_cmd),
    .lnk_posted(lnk_posted), .lnk_pass(lnk_pass), .lnk_rsp_pass(lnk_rsp_pass),
    .lnk_addr(lnk_addr), .lnk_data(lnk_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
    .rsp_data(rsp_data),
    .cmp_valid(cmp_valid), .cmp_ack(cmp_ack), .cmp_data(cmp_data), .cmp_err(cmp_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int   n_chk = 0, n_fail = 0, cyc = 0;
  int   outst = 0, pend_rsp = 0;
  bit   fpend = 0, hold_pend = 0, last_fire = 0;
  int   lnk_pct = 70, rsp_pct = 60, ack_pct = 70;
  bit   rsp_en = 1;
  pkt_t held;
  pkt_t lq[$];
  req_t rq[$];
  cmp_t cq[$];

  task automatic chk(input bit ok, input string rid, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rid, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic pkt_t exp_pkt(input req_t r);
    pkt_t p;
    p.addr = r.addr;
    p.data = r.data;
    case (r.kind)
      2'd0:    begin p.cmd = 2'd0; p.posted = 1'b1; p.pass = r.hi; p.rpass = 1'b0; end
      2'd1:    begin p.cmd = 2'd1; p.posted = 1'b0; p.pass = r.hi; p.rpass = 1'b1; end
      default: begin p.cmd = 2'd2; p.posted = 1'b0; p.pass = 1'b0; p.rpass = 1'b0; end
    endcase
    return p;
  endfunction

  function automatic string pkt_rid(input pkt_t p);
    if (p.cmd == 2'd0) return p.pass ? "R1" : "R3";
    if (p.cmd == 2'd1) return p.pass ? "R2" : "R4";
    return "R5";
  endfunction

  function automatic cmp_t exp_cmp(input logic [1:0] st, input logic [DW-1:0] d);
    cmp_t c;
    c.st   = st;
    c.err  = (st[1] == 1'b1);
    c.data = (st == 2'd1) ? '1 : d;
    return c;
  endfunction

  function automatic req_t rand_req();
    req_t r;
    int   w = $urandom_range(99);
    r.kind = (w < 35) ? 2'd0 : (w < 70) ? 2'd1 : (w < 85) ? 2'd2 : 2'd3;
    r.hi   = 1'($urandom_range(1));
    r.addr = AW'($urandom);
    r.data = DW'($urandom);
    return r;
  endfunction

  task automatic push_req(input logic hi, input logic [1:0] kind);
    req_t r;
    r.hi = hi; r.kind = kind; r.addr = AW'($urandom); r.data = DW'($urandom);
    rq.push_back(r);
  endtask

  task automatic step();
    pkt_t       got, ex;
    cmp_t       cg, ce;
    bit         exp_rdy, rfire, fence_fire;
    int         w;
    string      rid;
    @(negedge clk);
    cyc++;
    if (cyc > WD_LIMIT) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <= %0d cycles", cyc, WD_LIMIT);
      finish_run();
    end
    got = {lnk_cmd, lnk_posted, lnk_pass, lnk_rsp_pass, lnk_addr, lnk_data};
    if (hold_pend)
      chk(lnk_valid && got == held, "R12", "stalled descriptor changed", longint'(got), longint'(held));
    chk(lnk_valid == (lq.size() != 0), "R11", "lnk_valid vs packets pending", lnk_valid, lq.size() != 0);
    chk(cmp_valid == (cq.size() != 0), "R9", "cmp_valid vs completions pending", cmp_valid, cq.size() != 0);

    if (rq.size() != 0) begin
      req_valid = 1'b1; req_hipri = rq[0].hi; req_kind = rq[0].kind;
      req_addr = rq[0].addr; req_data = rq[0].data;
    end else begin
      req_valid = 1'b0; req_hipri = 1'($urandom_range(1)); req_kind = 2'($urandom_range(3));
      req_addr = AW'($urandom); req_data = DW'($urandom);
    end
    lnk_ready = ($urandom_range(99) < lnk_pct);
    if (rsp_en && pend_rsp > 0 && $urandom_range(99) < rsp_pct) begin
      w = $urandom_range(99);
      rsp_valid  = 1'b1;
      rsp_status = (w < 55) ? 2'd0 : (w < 85) ? 2'd1 : (w < 93) ? 2'd2 : 2'd3;
      rsp_data   = DW'($urandom);
    end else begin
      rsp_valid = 1'b0; rsp_status = 2'd0; rsp_data = DW'($urandom);
    end
    cmp_ack = ($urandom_range(99) < ack_pct);
    #1;

    if (req_valid) begin
      exp_rdy = !fpend && (!lnk_valid || lnk_ready) && !(req_kind == 2'd1 && outst == MAXO);
      rid = fpend ? "R6" : (req_kind == 2'd1 && outst == MAXO) ? "R10" : "R11";
      chk(req_ready == exp_rdy, rid, "req_ready", req_ready, exp_rdy);
    end
    chk(rsp_ready == (!cmp_valid || cmp_ack), "R9", "rsp_ready", rsp_ready, !cmp_valid || cmp_ack);

    hold_pend = lnk_valid && !lnk_ready;
    held      = got;
    if (lnk_valid && lnk_ready && lq.size() != 0) begin
      ex = lq.pop_front();
      chk(got == ex, pkt_rid(ex), "link descriptor", longint'(got), longint'(ex));
      if (ex.cmd == 2'd1) pend_rsp++;
    end
    if (cmp_valid && cmp_ack && cq.size() != 0) begin
      ce = cq.pop_front();
      cg.st = ce.st; cg.err = cmp_err; cg.data = cmp_data;
      chk(cg == ce, (ce.st == 2'd1) ? "R8" : "R9", "completion", longint'(cg), longint'(ce));
      outst--;
    end
    if (rsp_valid && rsp_ready) begin
      cq.push_back(exp_cmp(rsp_status, rsp_data));
      pend_rsp--;
    end
    rfire      = req_valid && req_ready;
    fence_fire = rfire && req_kind == 2'd3;
    if (rfire) begin
      if (req_kind != 2'd3) lq.push_back(exp_pkt(rq[0]));
      if (req_kind == 2'd1) outst++;
      void'(rq.pop_front());
    end
    last_fire = rfire;
    fpend = (fpend || fence_fire) && (outst != 0);
  endtask

  task automatic drain();
    int n = 0;
    while ((rq.size() != 0 || lq.size() != 0 || cq.size() != 0 || outst != 0) && n < 3000) begin
      step();
      n++;
    end
    chk(n < 3000, "R6", "drain did not finish", n, 3000);
  endtask

  initial begin
    rst = 1'b1; req_valid = 0; req_hipri = 0; req_kind = 0; req_addr = 0; req_data = 0;
    lnk_ready = 0; rsp_valid = 0; rsp_status = 0; rsp_data = 0; cmp_ack = 0;
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R13: idle state straight after reset
    chk(!lnk_valid, "R13", "lnk_valid after reset", lnk_valid, 0);
    chk(!cmp_valid, "R13", "cmp_valid after reset", cmp_valid, 0);
    chk(req_ready, "R13", "req_ready after reset", req_ready, 1);

    // Directed: every translation, then the all-ones override (R1..R5, R8)
    lnk_pct = 100;
    push_req(1, 0); push_req(1, 1); push_req(0, 0); push_req(0, 1);
    push_req(0, 2); push_req(1, 2);
    drain();

    // Directed R7: fence with nothing outstanding retires at once
    push_req(0, 3); push_req(0, 0);
    step();
    chk(last_fire, "R7", "fence accepted at once", last_fire, 1);
    step();
    chk(last_fire, "R7", "request after fence accepted next cycle", last_fire, 1);
    drain();

    // Directed R10: saturate the read counter with responses withheld
    rsp_en = 0;
    for (int i = 0; i <= MAXO; i++) push_req(1'($urandom_range(1)), 1);
    repeat (MAXO + 6) step();
    chk(outst == MAXO, "R10", "outstanding reads", outst, MAXO);
    chk(req_valid && !req_ready, "R10", "extra read stalled", req_ready, 0);
    rsp_en = 1;
    drain();

    // Directed R6: fence behind reads holds the following write
    rsp_en = 0;
    push_req(0, 1); push_req(1, 1); push_req(0, 3); push_req(1, 0);
    repeat (8) step();
    chk(fpend && !req_ready, "R6", "write held behind fence", req_ready, 0);
    chk(!lnk_valid, "R6", "fence emitted no packet", lnk_valid, 0);
    rsp_en = 1;
    drain();

    // Random phases with varied back-pressure
    for (int ph = 0; ph < 4; ph++) begin
      lnk_pct = 30 + ph * 20;
      ack_pct = 90 - ph * 20;
      rsp_pct = 40 + ph * 15;
      for (int c = 0; c < 2000; c++) begin
        if (rq.size() < 3) rq.push_back(rand_req());
        step();
      end
      drain();
    end
    finish_run();
  end

endmodule